// File: doc/BRIEF.md
# Transmit Hold Queue and Descriptor Ring Manager

This block sits between the packet-switching logic and a media controller on the outbound side of an interface. It takes buffer handles for packets that are ready to send and keeps them in two stages. The first stage is a small transmit descriptor ring, four slots by default, which the media controller reads. The second is a bounded FIFO hold queue in front of the ring. For each arriving handle the block decides, in a single cycle, whether to link it into the ring, park it in the hold queue, or drop it and count the drop. Handles always leave the ring in the order they arrived.

The media controller reads the oldest ring entry through `tx_avail`/`tx_handle` and pulses `done_valid` once it has sent that entry. The block then removes the entry and returns its buffer handle on `free_valid`/`free_handle` one cycle later, so the handle can go back to its pool. In the same cycle it moves the oldest held handle into the slot that was freed. If a completion and a new handle arrive in the same cycle, the completion is handled first, and the hold queue gets the freed slot before the new handle is placed.

The ring depth, hold depth, handle width and drop-counter width are parameters. A parameter chooses whether the drop counter saturates or wraps. The index arithmetic picks a power-of-two or a modulo variant to suit the depth.

Top module: `txq_ring_mgr`

## Requirements
- R1: After reset, `pending_count`, `held_count` and `drop_count` are 0, and `tx_avail` and `free_valid` are low.
- R2: A handle offered on `in_valid` while the hold queue is empty and fewer than RING_DEPTH handles are pending is linked into the ring, and `pending_count` rises by one on the next cycle.
- R3: A handle offered while `pending_count` equals RING_DEPTH (ring full) and the hold queue has room is placed in the hold queue, and `held_count` rises by one.
- R4: Handles leave through `tx_handle` in their arrival order, whichever path they took. A non-empty hold queue always means the ring is full, so no new handle overtakes a held one.
- R5: A handle offered while the ring is full and `held_count` equals HOLD_DEPTH is dropped, `drop_count` rises by one, and both occupancy counts stay unchanged.
- R6: A `done_valid` pulse while the ring is not empty removes the oldest ring entry. On the next cycle `free_valid` is high and `free_handle` carries that entry's handle. With an empty hold queue, `pending_count` falls by one.
- R7: A completion while the hold queue is not empty moves the oldest held handle onto the ring. `pending_count` stays the same and `held_count` falls by one.
- R8: When a completion and a new handle arrive in the same cycle, the completion and the refill from the hold queue happen first. If the hold queue was empty, the new handle goes into the freed ring slot. Otherwise it joins the tail of the hold queue.
- R9: A `done_valid` pulse while the ring is empty is ignored: `free_valid` stays low and all counts are unchanged.
- R10: With DROP_SATURATE set, `drop_count` stops at its all-ones value and no longer wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A new outbound handle is offered this cycle |
| in_handle | input | HANDLE_W | Buffer handle of the offered packet |
| done_valid | input | 1 | Media side has finished sending the oldest ring entry |
| tx_avail | output | 1 | Ring holds at least one entry ready to send |
| tx_handle | output | HANDLE_W | Handle of the oldest ring entry |
| free_valid | output | 1 | A released handle is presented this cycle |
| free_handle | output | HANDLE_W | Handle returned for release to its pool |
| pending_count | output | $clog2(RING_DEPTH+1) | Number of handles linked into the ring |
| held_count | output | $clog2(HOLD_DEPTH+1) | Number of handles in the hold queue |
| drop_count | output | DROP_W | Number of handles dropped |

## Verification
The assertions assume that `done_valid` refers only to the entry currently shown on `tx_handle`, and that each completion pulse lasts one cycle. They also assume the media side never completes an entry it has not been shown, except in the deliberate empty-ring case covered by R9. The stimulus drives `done_valid` for a single cycle at a time. It mixes deliberate empty-ring completions with normal ones. The sweep changes how often handles and completions arrive, so the block spends long stretches with the hold queue full as well as with the ring nearly empty.

// File: rtl/txq_pkg.sv
package txq_pkg;

   // Outcome chosen for an offered handle in one cycle
   typedef enum logic [1:0] {
      PLACE_NONE = 2'd0,
      PLACE_RING = 2'd1,
      PLACE_HOLD = 2'd2,
      PLACE_DROP = 2'd3
   } place_e;

endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 16,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head_data,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   localparam int  IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit  IS_POW2 = (DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 1) begin : g_bad_depth
      $error("txq_fifo: DEPTH must be at least 1");
   end
   if (CW < $clog2(DEPTH + 1)) begin : g_bad_cw
      $error("txq_fifo: CW too narrow for DEPTH");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [IW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   // Index advance: natural wrap for power-of-two depths, compare otherwise
   if (IS_POW2) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_mod
      assign wr_nxt = (wr_ptr == IW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == IW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         count <= count + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   assign head_data = mem[rd_ptr];
   assign full      = (count == CW'(DEPTH));
   assign empty     = (count == '0);

   // Storage is never written past capacity (R3)
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |-> pop);
   // Nothing is taken from empty storage (R6)
   p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

endmodule

// File: rtl/txq_drop_ctr.sv
module txq_drop_ctr #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] value
);
   if (W < 1) begin : g_bad_w
      $error("txq_drop_ctr: W must be at least 1");
   end

   localparam logic [W-1:0] TOP = '1;

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n)                    value <= '0;
         else if (inc && value != TOP)  value <= value + 1'b1;
      end
      // Once at all-ones the count stays there (R10)
      p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (value == TOP) |=> (value == TOP));
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)   value <= '0;
         else if (inc) value <= value + 1'b1;
      end
   end

   // Count only moves on a drop (R5)
   p_move_on_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(value));

endmodule

// File: rtl/txq_steer.sv
module txq_steer
   import txq_pkg::*;
#(
   parameter int RING_DEPTH = 4,
   parameter int HOLD_DEPTH = 8,
   parameter int RCW        = $clog2(RING_DEPTH + 1),
   parameter int HCW        = $clog2(HOLD_DEPTH + 1)
) (
   input  logic           in_valid,
   input  logic           done_valid,
   input  logic [RCW-1:0] ring_cnt,
   input  logic [HCW-1:0] hold_cnt,
   output logic           cmpl_ok,
   output logic           hold_move,
   output place_e         place
);
   int ring_after;
   int hold_after;

   always_comb begin
      // Completion first: retire the oldest ring entry, refill from hold
      cmpl_ok    = done_valid && (ring_cnt != '0);
      hold_move  = cmpl_ok && (hold_cnt != '0);
      ring_after = int'(ring_cnt) - int'(cmpl_ok) + int'(hold_move);
      hold_after = int'(hold_cnt) - int'(hold_move);

      // Then the offered handle: ring only when nothing is waiting ahead
      place = PLACE_NONE;
      if (in_valid) begin
         if (hold_after == 0 && ring_after < RING_DEPTH)
            place = PLACE_RING;
         else if (hold_after < HOLD_DEPTH)
            place = PLACE_HOLD;
         else
            place = PLACE_DROP;
      end
   end

endmodule

// File: rtl/txq_ring_mgr.sv
module txq_ring_mgr
   import txq_pkg::*;
#(
   parameter int HANDLE_W      = 16,
   parameter int RING_DEPTH    = 4,
   parameter int HOLD_DEPTH    = 8,
   parameter int DROP_W        = 16,
   parameter bit DROP_SATURATE = 1'b1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               in_valid,
   input  logic [HANDLE_W-1:0]                in_handle,
   input  logic                               done_valid,
   output logic                               tx_avail,
   output logic [HANDLE_W-1:0]                tx_handle,
   output logic                               free_valid,
   output logic [HANDLE_W-1:0]                free_handle,
   output logic [$clog2(RING_DEPTH+1)-1:0]    pending_count,
   output logic [$clog2(HOLD_DEPTH+1)-1:0]    held_count,
   output logic [DROP_W-1:0]                  drop_count
);
   localparam int RCW = $clog2(RING_DEPTH + 1);
   localparam int HCW = $clog2(HOLD_DEPTH + 1);

   if (RING_DEPTH < 1) begin : g_bad_ring
      $error("txq_ring_mgr: RING_DEPTH must be at least 1");
   end
   if (HOLD_DEPTH < 1) begin : g_bad_hold
      $error("txq_ring_mgr: HOLD_DEPTH must be at least 1");
   end
   if (HANDLE_W < 1) begin : g_bad_handle
      $error("txq_ring_mgr: HANDLE_W must be at least 1");
   end

   logic                cmpl_ok, hold_move;
   place_e              place;
   logic                ring_push, ring_full, ring_empty;
   logic [HANDLE_W-1:0] ring_in, ring_head;
   logic                hold_full, hold_empty;
   logic [HANDLE_W-1:0] hold_head;

   txq_steer #(
      .RING_DEPTH(RING_DEPTH), .HOLD_DEPTH(HOLD_DEPTH), .RCW(RCW), .HCW(HCW)
   ) u_steer (
      .in_valid  (in_valid),
      .done_valid(done_valid),
      .ring_cnt  (pending_count),
      .hold_cnt  (held_count),
      .cmpl_ok   (cmpl_ok),
      .hold_move (hold_move),
      .place     (place)
   );

   assign ring_push = hold_move || (place == PLACE_RING);
   assign ring_in   = hold_move ? hold_head : in_handle;

   txq_fifo #(.DEPTH(RING_DEPTH), .W(HANDLE_W), .CW(RCW)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (ring_push),
      .push_data(ring_in),
      .pop      (cmpl_ok),
      .head_data(ring_head),
      .count    (pending_count),
      .full     (ring_full),
      .empty    (ring_empty)
   );

   txq_fifo #(.DEPTH(HOLD_DEPTH), .W(HANDLE_W), .CW(HCW)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (place == PLACE_HOLD),
      .push_data(in_handle),
      .pop      (hold_move),
      .head_data(hold_head),
      .count    (held_count),
      .full     (hold_full),
      .empty    (hold_empty)
   );

   txq_drop_ctr #(.W(DROP_W), .SATURATE(DROP_SATURATE)) u_drops (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (place == PLACE_DROP),
      .value(drop_count)
   );

   // Released handle, registered one cycle after the completion
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_valid  <= 1'b0;
         free_handle <= '0;
      end else begin
         free_valid <= cmpl_ok;
         if (cmpl_ok) free_handle <= ring_head;
      end
   end

   assign tx_avail  = !ring_empty;
   assign tx_handle = ring_head;

   // A refill from hold and a direct link never compete for the ring (R8)
   p_single_ring_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(hold_move && place == PLACE_RING));
   // Held handles exist only behind a full ring (R4)
   p_hold_behind_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_empty |-> ring_full);
   // Completion on a busy ring releases a handle next cycle (R6)
   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && tx_avail) |=> free_valid);
   // Completion on an empty ring is ignored (R9)
   p_ignore_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !tx_avail && !in_valid) |=>
         (!free_valid && $stable(pending_count) && $stable(held_count)));
   // Drops happen only with both stages full (R5)
   p_drop_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !done_valid && !hold_full) |=> $stable(drop_count));
   // Refill keeps the ring occupancy constant (R7)
   p_refill_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !hold_empty && !in_valid) |=>
         ($stable(pending_count) && held_count == $past(held_count) - 1'b1));

endmodule

// File: tb/tb_txq_ring_mgr.sv
module tb_txq_ring_mgr;
   localparam int HW   = 16;
   localparam int RING = 4;
   localparam int HOLD = 8;
   localparam int DW   = 4;
   localparam int DMAX = (1 << DW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [HW-1:0] in_handle = '0;
   logic          done_valid = 1'b0;
   logic          tx_avail, free_valid;
   logic [HW-1:0] tx_handle, free_handle;
   logic [$clog2(RING+1)-1:0] pending_count;
   logic [$clog2(HOLD+1)-1:0] held_count;
   logic [DW-1:0] drop_count;

   always #4 clk = ~clk;

   txq_ring_mgr #(
      .HANDLE_W(HW), .RING_DEPTH(RING), .HOLD_DEPTH(HOLD),
      .DROP_W(DW), .DROP_SATURATE(1'b1)
   ) dut (.*);

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int ring_m[$];
   int hold_m[$];
   int drops_m = 0;
   int next_h = 1;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag, input bit rv, input int rh);
      chk(tag, "pending_count", int'(pending_count), ring_m.size());
      chk(tag, "held_count", int'(held_count), hold_m.size());
      chk(tag, "drop_count", int'(drop_count), drops_m);
      chk(tag, "free_valid", int'(free_valid), int'(rv));
      if (rv) chk(tag, "free_handle", int'(free_handle), rh);
      chk("R4", "tx_avail", int'(tx_avail), int'(ring_m.size() != 0));
      if (ring_m.size() != 0) chk("R4", "tx_handle order", int'(tx_handle), ring_m[0]);
   endtask

   // One cycle: drive at a falling edge, check at the next falling edge
   task automatic step(input bit e, input bit c);
      bit    cok, hm, rv;
      int    rh;
      string tag;
      rv = 0; rh = 0;
      cok = c && ring_m.size() != 0;
      hm  = cok && hold_m.size() != 0;
      tag = "R1";
      if (c && !cok) tag = "R9";
      if (cok) begin
         rv = 1;
         rh = ring_m.pop_front();
         tag = "R6";
      end
      if (hm) begin
         ring_m.push_back(hold_m.pop_front());
         tag = "R7";
      end
      if (e) begin
         if (hold_m.size() == 0 && ring_m.size() < RING) begin
            ring_m.push_back(next_h);
            tag = cok ? "R8" : "R2";
         end else if (hold_m.size() < HOLD) begin
            hold_m.push_back(next_h);
            tag = cok ? "R8" : "R3";
         end else begin
            if (drops_m < DMAX) drops_m++;
            tag = (drops_m == DMAX) ? "R10" : "R5";
         end
      end
      in_valid   = e;
      in_handle  = HW'(next_h);
      done_valid = c;
      if (e) next_h = (next_h % 60000) + 1;
      @(negedge clk);
      in_valid   = 1'b0;
      done_valid = 1'b0;
      compare_all(tag, rv, rh);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R1", 1'b0, 0);

      // R2: fill the ring directly
      for (int i = 0; i < RING; i++) step(1, 0);
      // R3: overflow into hold queue until full
      for (int i = 0; i < HOLD; i++) step(1, 0);
      // R5: both stages full, drops
      for (int i = 0; i < 3; i++) step(1, 0);
      // R7: completions refilling from hold
      step(0, 1);
      step(0, 1);
      // R8: completion and new handle together, hold non-empty
      step(1, 1);
      // R6: drain everything
      for (int i = 0; i < RING + HOLD; i++) step(0, 1);
      // R9: completions on an empty ring
      step(0, 1);
      step(0, 1);
      // R8: ring full, hold empty, completion plus new handle -> ring
      for (int i = 0; i < RING; i++) step(1, 0);
      step(1, 1);
      for (int i = 0; i < RING; i++) step(0, 1);
      // R10: push drops past the counter maximum
      for (int i = 0; i < RING + HOLD + DMAX + 5; i++) step(1, 0);
      for (int i = 0; i < RING + HOLD; i++) step(0, 1);

      // Sweep: varying arrival and completion rates
      for (int phase = 0; phase < 8; phase++) begin
         for (int i = 0; i < 500; i++) begin
            int r;
            r = int'($urandom_range(0, 7));
            step(r < phase, ((r + i) % 8) >= phase);
         end
      end

      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule